// File: doc/BRIEF.md
# Fully Associative Address Translation Cache with Access Permissions

This block holds a small set of recent page translations and maps a virtual address to a physical address. On every lookup the incoming virtual page number is compared against all stored page numbers at once. When a valid entry matches and the access is allowed, the response carries the stored frame number with the untouched page offset below it. The result is registered and appears one cycle after the request.

A lookup faults when no valid entry matches. It also faults when a store reaches a page that is not writable, or when an instruction fetch reaches a page that is not executable. The fault carries a cause code, so that software can refill the entry, copy a shared read-only page before retrying the store, or reject the fetch. Software installs entries at an index it chooses. It clears the whole cache with one flush pulse, for example on a process switch.

Top module: `xlat_cache`

## Requirements
- R1: After reset no entry is valid and `rsp_valid` is 0, so any lookup made before the first fill faults with cause 0.
- R2: A lookup requested in cycle t (`lk_req`=1) produces `rsp_valid`=1 in cycle t+1. `rsp_valid` is 0 in a cycle that follows a cycle without a request, and the response fields keep their values over such a cycle.
- R3: A permitted lookup that hits returns `rsp_fault`=0 and `rsp_paddr` = {stored frame number, `lk_vaddr`[11:0]}.
- R4: When no valid entry holds the page number `lk_vaddr`[31:12], the response has `rsp_fault`=1 and `rsp_cause`=0, which is the miss code.
- R5: Access kind encoding on `lk_kind`: 0 = load, 1 = store, 2 = fetch, 3 = treated as a load. A store that hits an entry whose write bit is clear faults with `rsp_cause`=1. Loads that hit never fault, whatever the entry's write and execute bits.
- R6: A fetch that hits an entry whose execute bit is clear faults with `rsp_cause`=2. A store checks only the write bit and a fetch checks only the execute bit.
- R7: A `flush` pulse in cycle t clears every valid bit at the clock edge that ends cycle t, so a lookup in cycle t+1 misses. A fill in the same cycle as a flush is dropped.
- R8: A fill writes page number, frame number, write and execute bits into the slot given by `fill_idx` and marks that slot valid. The old contents of the slot are replaced. A lookup in the same cycle as a fill or a flush sees the contents from before the update.
- R9: When several valid entries hold the same page number, the entry with the lowest index decides the frame and the permissions.
- R10: On a faulting response `rsp_paddr` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| lk_req | input | 1 | Lookup request |
| lk_vaddr | input | 32 | Virtual address to translate |
| lk_kind | input | 2 | Access kind: 0 load, 1 store, 2 fetch, 3 load |
| fill_en | input | 1 | Install an entry |
| fill_idx | input | 4 | Slot to install into |
| fill_vpn | input | 20 | Virtual page number of the new entry |
| fill_pfn | input | 20 | Physical frame number of the new entry |
| fill_wr | input | 1 | Write permission of the new entry |
| fill_ex | input | 1 | Execute permission of the new entry |
| flush | input | 1 | Invalidate every entry |
| rsp_valid | output | 1 | Response valid, one cycle after `lk_req` |
| rsp_paddr | output | 32 | Translated physical address, 0 on fault |
| rsp_fault | output | 1 | Lookup faulted |
| rsp_cause | output | 2 | Fault cause: 0 miss, 1 write-protect, 2 no-execute |

## Verification
The bench targets duplicate page numbers in several slots. A design that chose the highest or the last-written match would return the wrong frame or the wrong permission there. It issues a fill and a lookup, and a flush and a lookup, in the same cycle; a design that bypassed new contents into the lookup would hit where it should miss or the reverse. It mixes store and fetch kinds against pages with only one of the two permissions set. Swapped permission checks, or cause codes on the wrong kind, show up as wrong fault flags. It also sends a flush together with a fill, so a design that let the fill survive would hit after the flush.

// File: rtl/xlat_cache_pkg.sv
package xlat_cache_pkg;

  typedef enum logic [1:0] {
    ACC_LOAD     = 2'd0,
    ACC_STORE    = 2'd1,
    ACC_FETCH    = 2'd2,
    ACC_LOAD_ALT = 2'd3
  } acc_kind_e;

  typedef enum logic [1:0] {
    CAUSE_MISS   = 2'd0,
    CAUSE_WPROT  = 2'd1,
    CAUSE_NOEXEC = 2'd2
  } fault_cause_e;

endpackage

// File: rtl/xlat_entry_store.sv
module xlat_entry_store #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        fill_en,
  input  logic [IDX_W-1:0]            fill_idx,
  input  logic [VPN_W-1:0]            fill_vpn,
  input  logic [PFN_W-1:0]            fill_pfn,
  input  logic                        fill_wr,
  input  logic                        fill_ex,
  input  logic                        flush,
  output logic [N-1:0]                ent_vld,
  output logic [N-1:0][VPN_W-1:0]     ent_vpn,
  output logic [N-1:0][PFN_W-1:0]     ent_pfn,
  output logic [N-1:0]                ent_wr,
  output logic [N-1:0]                ent_ex
);

  for (genvar g = 0; g < N; g++) begin : g_slot
    logic sel;
    logic vld_d;
    logic load_en;

    always_comb begin
      sel     = fill_en && (fill_idx == IDX_W'(g));
      load_en = sel && !flush;
      if (flush) begin
        vld_d = 1'b0;
      end else if (sel) begin
        vld_d = 1'b1;
      end else begin
        vld_d = ent_vld[g];
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        ent_vld[g] <= 1'b0;
      end else begin
        ent_vld[g] <= vld_d;
      end
    end

    always_ff @(posedge clk) begin
      if (load_en) begin
        ent_vpn[g] <= fill_vpn;
        ent_pfn[g] <= fill_pfn;
        ent_wr[g]  <= fill_wr;
        ent_ex[g]  <= fill_ex;
      end
    end
  end

endmodule

// File: rtl/xlat_match.sv
module xlat_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  localparam int IDX_W = $clog2(N)
) (
  input  logic [N-1:0]            ent_vld,
  input  logic [N-1:0][VPN_W-1:0] ent_vpn,
  input  logic [VPN_W-1:0]        key_vpn,
  output logic                    hit,
  output logic [IDX_W-1:0]        hit_idx
);

  logic [N-1:0] match;

  for (genvar g = 0; g < N; g++) begin : g_cmp
    assign match[g] = ent_vld[g] && (ent_vpn[g] == key_vpn);
  end

  always_comb begin
    hit_idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit_idx = IDX_W'(i);
      end
    end
    hit = |match;
  end

endmodule

// File: rtl/xlat_perm.sv
module xlat_perm
  import xlat_cache_pkg::*;
(
  input  logic         hit,
  input  logic         may_write,
  input  logic         may_exec,
  input  logic [1:0]   kind,
  output logic         fault,
  output fault_cause_e cause
);

  always_comb begin
    fault = 1'b0;
    cause = CAUSE_MISS;
    if (!hit) begin
      fault = 1'b1;
      cause = CAUSE_MISS;
    end else begin
      unique case (acc_kind_e'(kind))
        ACC_STORE: begin
          if (!may_write) begin
            fault = 1'b1;
            cause = CAUSE_WPROT;
          end
        end
        ACC_FETCH: begin
          if (!may_exec) begin
            fault = 1'b1;
            cause = CAUSE_NOEXEC;
          end
        end
        default: begin
          fault = 1'b0;
          cause = CAUSE_MISS;
        end
      endcase
    end
  end

endmodule

// File: rtl/xlat_cache.sv
module xlat_cache
  import xlat_cache_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PFN_W = 20,
  parameter int OFF_W = 12,
  localparam int IDX_W = $clog2(N),
  localparam int VA_W  = VPN_W + OFF_W,
  localparam int PA_W  = PFN_W + OFF_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             lk_req,
  input  logic [VA_W-1:0]  lk_vaddr,
  input  logic [1:0]       lk_kind,
  input  logic             fill_en,
  input  logic [IDX_W-1:0] fill_idx,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PFN_W-1:0] fill_pfn,
  input  logic             fill_wr,
  input  logic             fill_ex,
  input  logic             flush,
  output logic             rsp_valid,
  output logic [PA_W-1:0]  rsp_paddr,
  output logic             rsp_fault,
  output logic [1:0]       rsp_cause
);

  logic [N-1:0]            ent_vld;
  logic [N-1:0][VPN_W-1:0] ent_vpn;
  logic [N-1:0][PFN_W-1:0] ent_pfn;
  logic [N-1:0]            ent_wr;
  logic [N-1:0]            ent_ex;

  logic                    hit;
  logic [IDX_W-1:0]        hit_idx;
  logic                    sel_wr;
  logic                    sel_ex;
  logic [PFN_W-1:0]        sel_pfn;
  logic                    chk_fault;
  fault_cause_e            chk_cause;

  logic                    rsp_valid_d;
  logic                    rsp_en;
  logic [PA_W-1:0]         rsp_paddr_d;
  logic                    rsp_fault_d;
  logic [1:0]              rsp_cause_d;

  xlat_entry_store #(.N(N), .VPN_W(VPN_W), .PFN_W(PFN_W)) u_store (
    .clk      (clk),
    .rst_n    (rst_n),
    .fill_en  (fill_en),
    .fill_idx (fill_idx),
    .fill_vpn (fill_vpn),
    .fill_pfn (fill_pfn),
    .fill_wr  (fill_wr),
    .fill_ex  (fill_ex),
    .flush    (flush),
    .ent_vld  (ent_vld),
    .ent_vpn  (ent_vpn),
    .ent_pfn  (ent_pfn),
    .ent_wr   (ent_wr),
    .ent_ex   (ent_ex)
  );

  xlat_match #(.N(N), .VPN_W(VPN_W)) u_match (
    .ent_vld (ent_vld),
    .ent_vpn (ent_vpn),
    .key_vpn (lk_vaddr[VA_W-1:OFF_W]),
    .hit     (hit),
    .hit_idx (hit_idx)
  );

  always_comb begin
    sel_pfn = ent_pfn[hit_idx];
    sel_wr  = ent_wr[hit_idx];
    sel_ex  = ent_ex[hit_idx];
  end

  xlat_perm u_perm (
    .hit       (hit),
    .may_write (sel_wr),
    .may_exec  (sel_ex),
    .kind      (lk_kind),
    .fault     (chk_fault),
    .cause     (chk_cause)
  );

  // next-state for the response stage
  always_comb begin
    rsp_valid_d = lk_req;
    rsp_en      = lk_req;
    rsp_fault_d = chk_fault;
    rsp_cause_d = chk_cause;
    if (chk_fault) begin
      rsp_paddr_d = '0;
    end else begin
      rsp_paddr_d = {sel_pfn, lk_vaddr[OFF_W-1:0]};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_paddr <= '0;
      rsp_fault <= 1'b0;
      rsp_cause <= 2'd0;
    end else begin
      rsp_valid <= rsp_valid_d;
      if (rsp_en) begin
        rsp_paddr <= rsp_paddr_d;
        rsp_fault <= rsp_fault_d;
        rsp_cause <= rsp_cause_d;
      end
    end
  end

endmodule

// File: rtl/xlat_cache_chk.sv
module xlat_cache_chk #(
  parameter int VA_W  = 32,
  parameter int PA_W  = 32,
  parameter int OFF_W = 12
) (
  input logic            clk,
  input logic            rst_n,
  input logic            lk_req,
  input logic [VA_W-1:0] lk_vaddr,
  input logic [1:0]      lk_kind,
  input logic            flush,
  input logic            rsp_valid,
  input logic [PA_W-1:0] rsp_paddr,
  input logic            rsp_fault,
  input logic [1:0]      rsp_cause
);

  AST_RESP_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    lk_req |=> rsp_valid); // R2

  AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    !lk_req |=> (!rsp_valid && $stable(rsp_paddr) && $stable(rsp_fault))); // R2

  AST_OFFSET_KEPT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_fault) |-> rsp_paddr[OFF_W-1:0] == $past(lk_vaddr[OFF_W-1:0])); // R3

  AST_LOAD_NEVER_PROT: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && ($past(lk_kind) == 2'd0 || $past(lk_kind) == 2'd3))
      |-> !(rsp_fault && rsp_cause != 2'd0)); // R5

  AST_WPROT_ONLY_STORE: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && rsp_cause == 2'd1) |-> $past(lk_kind) == 2'd1); // R5

  AST_NOEXEC_ONLY_FETCH: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault && rsp_cause == 2'd2) |-> $past(lk_kind) == 2'd2); // R6

  AST_CAUSE_LEGAL: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_cause != 2'd3); // R6

  AST_FLUSH_MISSES: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(flush) && lk_req) |=> (rsp_fault && rsp_cause == 2'd0)); // R7

  AST_FAULT_ZERO_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && rsp_fault) |-> rsp_paddr == '0); // R10

endmodule

bind xlat_cache xlat_cache_chk #(.VA_W(VA_W), .PA_W(PA_W), .OFF_W(OFF_W)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .lk_req    (lk_req),
  .lk_vaddr  (lk_vaddr),
  .lk_kind   (lk_kind),
  .flush     (flush),
  .rsp_valid (rsp_valid),
  .rsp_paddr (rsp_paddr),
  .rsp_fault (rsp_fault),
  .rsp_cause (rsp_cause)
);

// File: tb/xlat_cache_tb_top.sv
`timescale 1ns/1ps
module xlat_cache_tb_top;

  localparam int N = 16;

  logic        clk;
  logic        rst_n;
  logic        lk_req;
  logic [31:0] lk_vaddr;
  logic [1:0]  lk_kind;
  logic        fill_en;
  logic [3:0]  fill_idx;
  logic [19:0] fill_vpn;
  logic [19:0] fill_pfn;
  logic        fill_wr;
  logic        fill_ex;
  logic        flush;
  logic        rsp_valid;
  logic [31:0] rsp_paddr;
  logic        rsp_fault;
  logic [1:0]  rsp_cause;

  int errors;
  int checks;
  bit done;

  logic        m_v [N];
  logic [19:0] m_vpn [N];
  logic [19:0] m_pfn [N];
  logic        m_w [N];
  logic        m_x [N];

  xlat_cache dut_i (
    .clk(clk), .rst_n(rst_n), .lk_req(lk_req), .lk_vaddr(lk_vaddr), .lk_kind(lk_kind),
    .fill_en(fill_en), .fill_idx(fill_idx), .fill_vpn(fill_vpn), .fill_pfn(fill_pfn),
    .fill_wr(fill_wr), .fill_ex(fill_ex), .flush(flush),
    .rsp_valid(rsp_valid), .rsp_paddr(rsp_paddr), .rsp_fault(rsp_fault), .rsp_cause(rsp_cause)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic void model_expect(input logic [31:0] va, input logic [1:0] kind,
                                       output logic fault, output logic [1:0] cause,
                                       output logic [31:0] pa);
    int hit_i;
    hit_i = -1;
    for (int i = N - 1; i >= 0; i--) begin
      if (m_v[i] && m_vpn[i] == va[31:12]) hit_i = i;
    end
    fault = 1'b0; cause = 2'd0; pa = 32'd0;
    if (hit_i < 0) begin
      fault = 1'b1; cause = 2'd0;
    end else if (kind == 2'd1 && !m_w[hit_i]) begin
      fault = 1'b1; cause = 2'd1;
    end else if (kind == 2'd2 && !m_x[hit_i]) begin
      fault = 1'b1; cause = 2'd2;
    end else begin
      pa = {m_pfn[hit_i], va[11:0]};
    end
  endfunction

  // one cycle of stimulus: drive at negedge, check at the following negedge
  task automatic step(input bit req, input logic [31:0] va, input logic [1:0] kind,
                      input bit fe, input logic [3:0] fi, input logic [19:0] fv,
                      input logic [19:0] fp, input bit fw, input bit fx, input bit fl,
                      input string tag);
    logic ef; logic [1:0] ec; logic [31:0] ea;
    logic [31:0] old_pa; logic old_f;
    lk_req = req; lk_vaddr = va; lk_kind = kind;
    fill_en = fe; fill_idx = fi; fill_vpn = fv; fill_pfn = fp; fill_wr = fw; fill_ex = fx;
    flush = fl;
    model_expect(va, kind, ef, ec, ea);
    old_pa = rsp_paddr; old_f = rsp_fault;
    @(posedge clk);
    if (fl) begin
      for (int i = 0; i < N; i++) m_v[i] = 1'b0;
    end else if (fe) begin
      m_v[fi] = 1'b1; m_vpn[fi] = fv; m_pfn[fi] = fp; m_w[fi] = fw; m_x[fi] = fx;
    end
    @(negedge clk);
    if (req) begin
      chk(rsp_valid == 1'b1, {tag, " R2 valid"}, 64'(rsp_valid), 64'd1);
      chk(rsp_fault == ef, {tag, " fault"}, 64'(rsp_fault), 64'(ef));
      if (ef) chk(rsp_cause == ec, {tag, " cause"}, 64'(rsp_cause), 64'(ec));
      chk(rsp_paddr == ea, {tag, " paddr R3/R10"}, 64'(rsp_paddr), 64'(ea));
    end else begin
      chk(rsp_valid == 1'b0 && rsp_paddr == old_pa && rsp_fault == old_f,
          {tag, " R2 idle"}, 64'({rsp_valid, rsp_paddr}), 64'({1'b0, old_pa}));
    end
  endtask

  task automatic look(input logic [31:0] va, input logic [1:0] kind, input string tag);
    step(1'b1, va, kind, 1'b0, 4'd0, 20'd0, 20'd0, 1'b0, 1'b0, 1'b0, tag);
  endtask

  task automatic fill(input logic [3:0] fi, input logic [19:0] fv, input logic [19:0] fp,
                      input bit fw, input bit fx, input string tag);
    step(1'b0, 32'd0, 2'd0, 1'b1, fi, fv, fp, fw, fx, 1'b0, tag);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog: actual=hung expected=finished");
      $display("  Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [19:0] pool [8];
    errors = 0; checks = 0; done = 1'b0;
    void'($urandom(32'd4242));
    for (int i = 0; i < N; i++) begin
      m_v[i] = 1'b0; m_vpn[i] = '0; m_pfn[i] = '0; m_w[i] = 1'b0; m_x[i] = 1'b0;
    end
    for (int k = 0; k < 8; k++) pool[k] = 20'h00400 + 20'(k * 37);
    lk_req = 0; lk_vaddr = 0; lk_kind = 0; fill_en = 0; fill_idx = 0;
    fill_vpn = 0; fill_pfn = 0; fill_wr = 0; fill_ex = 0; flush = 0;
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 reset valid", 64'(rsp_valid), 64'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(rsp_valid == 1'b0, "R1 post-reset valid", 64'(rsp_valid), 64'd0);

    // R1/R4: empty cache misses
    look(32'h0040_0123, 2'd0, "R1 R4 empty");
    // R3: fill and hit, offset extremes
    fill(4'd0, 20'h12345, 20'hABCDE, 1'b1, 1'b1, "R8 fill0");
    look(32'h1234_5000, 2'd0, "R3 off0");
    look(32'h1234_5FFF, 2'd1, "R3 offmax store");
    look(32'h1234_6000, 2'd0, "R4 neighbour miss");
    // R5/R6: permission mixes
    fill(4'd1, 20'h00077, 20'h00100, 1'b0, 1'b1, "R8 ro-x");
    fill(4'd2, 20'h00088, 20'h00200, 1'b1, 1'b0, "R8 rw-nx");
    look(32'h0007_7010, 2'd1, "R5 store ro");
    look(32'h0007_7010, 2'd0, "R5 load ro");
    look(32'h0007_7010, 2'd3, "R5 load alt ro");
    look(32'h0007_7010, 2'd2, "R6 fetch x");
    look(32'h0008_8020, 2'd2, "R6 fetch nx");
    look(32'h0008_8020, 2'd1, "R6 store nx ok");
    look(32'h0008_8020, 2'd3, "R5 load nx");
    // R9: duplicates, lowest index wins
    fill(4'd9, 20'h00555, 20'h09999, 1'b1, 1'b1, "R8 dup hi");
    fill(4'd3, 20'h00555, 20'h03333, 1'b0, 1'b0, "R8 dup lo");
    look(32'h0055_5444, 2'd0, "R9 dup load");
    look(32'h0055_5444, 2'd1, "R9 dup store");
    // R8: overwrite slot, same-cycle fill sees old contents
    step(1'b1, 32'h0055_5444, 2'd0, 1'b1, 4'd3, 20'h00556, 20'h04444, 1'b1, 1'b1, 1'b0,
         "R8 fill+lookup old");
    look(32'h0055_5444, 2'd0, "R8 R9 after overwrite");
    step(1'b1, 32'h00F0_F00F, 2'd0, 1'b1, 4'd15, 20'h00F0F, 20'hFFFFF, 1'b1, 1'b1, 1'b0,
         "R8 fill15 same-cycle miss");
    look(32'h00F0_F00F, 2'd0, "R8 slot15 hit");
    // R7: flush with lookup in the same cycle, then miss; flush beats fill
    step(1'b1, 32'h1234_5678, 2'd0, 1'b0, 4'd0, 20'd0, 20'd0, 1'b0, 1'b0, 1'b1,
         "R7 flush same-cycle old");
    look(32'h1234_5678, 2'd0, "R7 after flush");
    step(1'b0, 32'd0, 2'd0, 1'b1, 4'd4, 20'h00999, 20'h00111, 1'b1, 1'b1, 1'b1,
         "R7 flush+fill");
    look(32'h0099_9000, 2'd0, "R7 fill dropped");

    // constrained random mix
    for (int n = 0; n < 4000; n++) begin
      bit rq, fe, fl;
      logic [31:0] va;
      rq = ($urandom_range(0, 3) != 0);
      fe = ($urandom_range(0, 3) == 0);
      fl = ($urandom_range(0, 63) == 0);
      va = {pool[$urandom_range(0, 7)], 12'($urandom)};
      step(rq, va, 2'($urandom_range(0, 3)), fe, 4'($urandom_range(0, 15)),
           pool[$urandom_range(0, 7)], 20'($urandom), 1'($urandom), 1'($urandom), fl,
           "R3 R4 R5 R6 R7 R8 R9 random");
    end

    done = 1'b1;
    $display("  Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule